// File: doc/BRIEF.md
# Privilege, Window and Trap Controller

This block keeps the supervisor state of a 32-bit RISC core. That state is the status word, the window-invalid mask, the trap base register and the current window pointer inside the status word. The decoder in front of it sends one-cycle operation strobes with two operand values and the current PC and nPC. The block checks each privileged register access against the supervisor bit. It moves the window pointer for save, restore, trap entry and return-from-trap. It selects one trap when several requests arrive in the same cycle.

When a trap is taken, the block sends a registered redirect (new PC and nPC) back to the fetch unit. In the same cycle it sends a write request for the two link registers of the newly entered window to the register file. The address-space identifiers for instruction fetch and data access come straight from the supervisor bit, so they follow every change to the status word with no lag.

Status-word layout, used by all requirements:
- bits 4:0: window pointer
- bit 5: trap enable
- bit 6: previous supervisor
- bit 7: supervisor
- bits 11:8: interrupt level
- bit 12: FP enable
- bit 13: coprocessor enable
- bits 23:20: condition codes
- bits 19:14: always zero
- bits 31:24: the fixed parameter `IMPL_VER`

Trap type codes: illegal operation is 2, privilege violation is 3, FP disabled is 4.

Top module: `ptc_core`

## Requirements
- R1: A synchronous reset sets supervisor=1, previous-supervisor=1, trap-enable=0, window=0, level=0, FP enable=0, mask=0 and base=0. After reset the identifiers read 9 (instruction) and 11 (data).
- R2: The identifiers are 9 and 11 while supervisor=1, and 8 and 10 while supervisor=0. They follow the status word in the same cycle it changes.
- R3: In user mode, a read or write strobe for the status word, mask or base requests trap type 3 and leaves all three registers unchanged.
- R4: A status-word write loads A XOR B, with bits 19:14 forced to zero and bits 31:24 kept at `IMPL_VER`. If the new window field is 7 or more, trap type 2 is requested and the word is not changed.
- R5: A mask write stores (A XOR B) AND 0x7F. A base write stores (A XOR B) AND 0xFFFFF000.
- R6: Save moves the window to (w+6) mod 7. Restore moves it to (w+1) mod 7, so 0 wraps to 6 and 6 wraps to 0.
- R7: Taking a trap does the following:
  - copies supervisor into previous-supervisor, then sets supervisor=1 and trap-enable=0;
  - moves the window to (w+6) mod 7;
  - puts the trap type into base bits 11:4;
  - one cycle later, pulses the redirect with PC = new base and nPC = new base + 4.
  No other operation strobed in that cycle takes effect.
- R8: In the same cycle as the redirect, the link write pulses with the new window number, the old PC (for link register 17) and the old nPC (for link register 18).
- R9: A software trap strobe requests type 128 + ((A + B) AND 0x7F).
- R10: An FP strobe while FP enable=0 requests type 4. An unrecognised-operation strobe requests type 2.
- R11: When several trap requests are active in one cycle, the one with the lowest type number is taken.
- R12: While trap-enable=0, trap requests are ignored. No redirect, no link write and no state change occur, and the operation that raised the request has no effect.
- R13: Return-from-trap does the following:
  - copies previous-supervisor into supervisor and sets trap-enable=1;
  - moves the window to (w+1) mod 7;
  - redirects with PC = incoming nPC and nPC = A + B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| op_rd_psr | input | 1 | status word read strobe |
| op_rd_wim | input | 1 | mask read strobe |
| op_rd_tbr | input | 1 | base read strobe |
| op_wr_psr | input | 1 | status word write strobe |
| op_wr_wim | input | 1 | mask write strobe |
| op_wr_tbr | input | 1 | base write strobe |
| op_save | input | 1 | window save strobe |
| op_restore | input | 1 | window restore strobe |
| op_rett | input | 1 | return-from-trap strobe |
| op_swtrap | input | 1 | taken software trap strobe |
| op_fp | input | 1 | FP operation strobe |
| op_bad | input | 1 | unrecognised operation strobe |
| opnd_a | input | 32 | first operand |
| opnd_b | input | 32 | second operand |
| pc_in | input | 32 | PC of the current operation |
| npc_in | input | 32 | nPC of the current operation |
| ext_trap_req | input | 1 | external trap request |
| ext_trap_type | input | 8 | type of the external trap |
| psr_out | output | 32 | status word |
| wim_out | output | 32 | window-invalid mask |
| tbr_out | output | 32 | trap base register |
| redir_valid | output | 1 | redirect pulse |
| redir_pc | output | 32 | redirect PC |
| redir_npc | output | 32 | redirect nPC |
| link_we | output | 1 | link register write pulse |
| link_cwp | output | 5 | window receiving the link writes |
| link_pc | output | 32 | value for link register 17 |
| link_npc | output | 32 | value for link register 18 |
| insn_asi | output | 8 | instruction address-space identifier |
| data_asi | output | 8 | data address-space identifier |

## Verification
The in-RTL properties check four things every cycle:
- the window pointer never leaves 0..6;
- the mask and base hold no bits outside their masks;
- a link write always comes with a redirect, supervisor mode, cleared trap enable and the new window number;
- no link write follows a cycle in which traps were disabled.

The exact values need the bench's scenarios. These include the trap vector arithmetic, the lowest-type arbitration, the XOR write data, the rejected window field, and user-mode accesses being refused. The bench compares them every cycle against a behavioural reference model.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int XLEN     = 32;
  localparam int TTW      = 8;
  localparam int PSR_ET   = 5;
  localparam int PSR_PS   = 6;
  localparam int PSR_S    = 7;
  localparam int PSR_EF   = 12;
  localparam logic [TTW-1:0] TT_ILLEGAL = 8'd2;
  localparam logic [TTW-1:0] TT_PRIV    = 8'd3;
  localparam logic [TTW-1:0] TT_FPDIS   = 8'd4;
  localparam logic [7:0] ASI_USER_I  = 8'd8;
  localparam logic [7:0] ASI_SUPER_I = 8'd9;
  localparam logic [7:0] ASI_USER_D  = 8'd10;
  localparam logic [7:0] ASI_SUPER_D = 8'd11;
endpackage

// File: rtl/ptc_win_step.sv
module ptc_win_step #(
  parameter int NWIN = 7,
  parameter int CWPW = 5
) (
  input  logic [CWPW-1:0] cwp,
  output logic [CWPW-1:0] cwp_dn,
  output logic [CWPW-1:0] cwp_up
);
  localparam logic [CWPW-1:0] TOP = CWPW'(NWIN - 1);

  assign cwp_dn = (cwp == '0) ? TOP : cwp - 1'b1;
  assign cwp_up = (cwp >= TOP) ? '0 : cwp + 1'b1;
endmodule

// File: rtl/ptc_trap_pick.sv
module ptc_trap_pick #(
  parameter int NSRC = 5,
  parameter int TTW  = 8
) (
  input  logic [NSRC-1:0]          req,
  input  logic [NSRC-1:0][TTW-1:0] tt,
  output logic                     hit,
  output logic [TTW-1:0]           tt_out
);
  // lowest type number wins
  always_comb begin
    hit    = 1'b0;
    tt_out = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && (!hit || tt[i] < tt_out)) begin
        hit    = 1'b1;
        tt_out = tt[i];
      end
    end
  end
endmodule

// File: rtl/ptc_core.sv
module ptc_core
  import ptc_pkg::*;
#(
  parameter int          NWIN     = 7,
  parameter int          CWPW     = 5,
  parameter logic [7:0]  IMPL_VER = 8'h20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_rd_psr,
  input  logic            op_rd_wim,
  input  logic            op_rd_tbr,
  input  logic            op_wr_psr,
  input  logic            op_wr_wim,
  input  logic            op_wr_tbr,
  input  logic            op_save,
  input  logic            op_restore,
  input  logic            op_rett,
  input  logic            op_swtrap,
  input  logic            op_fp,
  input  logic            op_bad,
  input  logic [31:0]     opnd_a,
  input  logic [31:0]     opnd_b,
  input  logic [31:0]     pc_in,
  input  logic [31:0]     npc_in,
  input  logic            ext_trap_req,
  input  logic [7:0]      ext_trap_type,
  output logic [31:0]     psr_out,
  output logic [31:0]     wim_out,
  output logic [31:0]     tbr_out,
  output logic            redir_valid,
  output logic [31:0]     redir_pc,
  output logic [31:0]     redir_npc,
  output logic            link_we,
  output logic [CWPW-1:0] link_cwp,
  output logic [31:0]     link_pc,
  output logic [31:0]     link_npc,
  output logic [7:0]      insn_asi,
  output logic [7:0]      data_asi
);
  localparam int NSRC = 5;
  localparam logic [XLEN-1:0] WIM_MASK = XLEN'((64'd1 << NWIN) - 64'd1);
  localparam logic [XLEN-1:0] PSR_RST  = {IMPL_VER, 16'h0000, 8'hC0};

  logic [XLEN-1:0] psr_q, wim_q, tbr_q;
  logic [XLEN-1:0] xv, sum, new_psr, vec;
  logic [CWPW-1:0] cwp_dn, cwp_up;
  logic            supv, priv_op, bad_cwp, take, any;
  logic [NSRC-1:0]          req;
  logic [NSRC-1:0][TTW-1:0] ttv;
  logic [TTW-1:0]           tt_sel;

  assign supv    = psr_q[PSR_S];
  assign xv      = opnd_a ^ opnd_b;
  assign sum     = opnd_a + opnd_b;
  assign priv_op = op_rd_psr | op_rd_wim | op_rd_tbr | op_wr_psr | op_wr_wim | op_wr_tbr;
  assign new_psr = {IMPL_VER, xv[23:20], 6'b000000, xv[13:0]};
  assign bad_cwp = xv[CWPW-1:0] >= CWPW'(NWIN);

  ptc_win_step #(.NWIN(NWIN), .CWPW(CWPW)) u_win (
    .cwp(psr_q[CWPW-1:0]), .cwp_dn(cwp_dn), .cwp_up(cwp_up)
  );

  assign req[0] = op_bad | (op_wr_psr & supv & bad_cwp);
  assign ttv[0] = TT_ILLEGAL;
  assign req[1] = ~supv & priv_op;
  assign ttv[1] = TT_PRIV;
  assign req[2] = op_fp & ~psr_q[PSR_EF];
  assign ttv[2] = TT_FPDIS;
  assign req[3] = op_swtrap;
  assign ttv[3] = {1'b1, sum[6:0]};
  assign req[4] = ext_trap_req;
  assign ttv[4] = ext_trap_type;

  ptc_trap_pick #(.NSRC(NSRC), .TTW(TTW)) u_pick (
    .req(req), .tt(ttv), .hit(any), .tt_out(tt_sel)
  );

  assign take = any & psr_q[PSR_ET];
  assign vec  = {tbr_q[31:12], tt_sel, 4'b0000};

  always_ff @(posedge clk) begin
    if (rst) begin
      psr_q       <= PSR_RST;
      wim_q       <= '0;
      tbr_q       <= '0;
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      redir_npc   <= '0;
      link_we     <= 1'b0;
      link_cwp    <= '0;
      link_pc     <= '0;
      link_npc    <= '0;
    end else begin
      redir_valid <= 1'b0;
      link_we     <= 1'b0;
      if (take) begin
        psr_q[PSR_PS]     <= psr_q[PSR_S];
        psr_q[PSR_S]      <= 1'b1;
        psr_q[PSR_ET]     <= 1'b0;
        psr_q[CWPW-1:0]   <= cwp_dn;
        tbr_q             <= vec;
        redir_valid       <= 1'b1;
        redir_pc          <= vec;
        redir_npc         <= vec + 32'd4;
        link_we           <= 1'b1;
        link_cwp          <= cwp_dn;
        link_pc           <= pc_in;
        link_npc          <= npc_in;
      end else if (!any) begin
        if (op_wr_psr) psr_q <= new_psr;
        if (op_wr_wim) wim_q <= xv & WIM_MASK;
        if (op_wr_tbr) tbr_q <= {xv[31:12], 12'h000};
        if (op_save)    psr_q[CWPW-1:0] <= cwp_dn;
        if (op_restore) psr_q[CWPW-1:0] <= cwp_up;
        if (op_rett) begin
          psr_q[PSR_S]    <= psr_q[PSR_PS];
          psr_q[PSR_ET]   <= 1'b1;
          psr_q[CWPW-1:0] <= cwp_up;
          redir_valid     <= 1'b1;
          redir_pc        <= npc_in;
          redir_npc       <= sum;
        end
      end
    end
  end

  assign psr_out  = psr_q;
  assign wim_out  = wim_q;
  assign tbr_out  = tbr_q;
  assign insn_asi = supv ? ASI_SUPER_I : ASI_USER_I;
  assign data_asi = supv ? ASI_SUPER_D : ASI_USER_D;

  // R6
  cwp_range_chk: assert property (@(posedge clk) disable iff (rst)
    psr_q[CWPW-1:0] < CWPW'(NWIN));
  // R5
  wim_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ((wim_q & ~WIM_MASK) == '0) && (tbr_q[3:0] == 4'h0));
  // R7
  trap_entry_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (redir_valid && psr_q[PSR_S] && !psr_q[PSR_ET]));
  // R8
  link_win_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (link_cwp == psr_q[CWPW-1:0]));
  // R12
  et_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !psr_q[PSR_ET] |=> !link_we);
endmodule

// File: tb/ptc_core_test.sv
`timescale 1ns/1ps
module ptc_core_test;
  localparam logic [7:0] IV = 8'h20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_rd_psr, op_rd_wim, op_rd_tbr, op_wr_psr, op_wr_wim, op_wr_tbr;
  logic op_save, op_restore, op_rett, op_swtrap, op_fp, op_bad, ext_trap_req;
  logic [31:0] opnd_a, opnd_b, pc_in, npc_in;
  logic [7:0]  ext_trap_type;
  logic [31:0] psr_out, wim_out, tbr_out, redir_pc, redir_npc, link_pc, link_npc;
  logic        redir_valid, link_we;
  logic [4:0]  link_cwp;
  logic [7:0]  insn_asi, data_asi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ptc_core #(.IMPL_VER(IV)) uut (
    .clk(clk), .rst(rst),
    .op_rd_psr(op_rd_psr), .op_rd_wim(op_rd_wim), .op_rd_tbr(op_rd_tbr),
    .op_wr_psr(op_wr_psr), .op_wr_wim(op_wr_wim), .op_wr_tbr(op_wr_tbr),
    .op_save(op_save), .op_restore(op_restore), .op_rett(op_rett),
    .op_swtrap(op_swtrap), .op_fp(op_fp), .op_bad(op_bad),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .pc_in(pc_in), .npc_in(npc_in),
    .ext_trap_req(ext_trap_req), .ext_trap_type(ext_trap_type),
    .psr_out(psr_out), .wim_out(wim_out), .tbr_out(tbr_out),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_npc(redir_npc),
    .link_we(link_we), .link_cwp(link_cwp), .link_pc(link_pc), .link_npc(link_npc),
    .insn_asi(insn_asi), .data_asi(data_asi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_s, m_ps, m_et, m_cwp, m_pil, m_ef, m_ec, m_icc;
  logic [31:0] m_wim, m_tbr, m_rpc, m_rnpc, m_lpc, m_lnpc;
  int m_rv, m_lw, m_lcwp;

  function automatic logic [31:0] m_psr();
    return (32'(IV) << 24) | (32'(m_icc) << 20) | (32'(m_ec) << 13) | (32'(m_ef) << 12) |
           (32'(m_pil) << 8) | (32'(m_s) << 7) | (32'(m_ps) << 6) | (32'(m_et) << 5) | 32'(m_cwp);
  endfunction

  always @(posedge clk) begin : model
    int cand[$];
    int best;
    logic [31:0] x;
    logic [31:0] sm;
    if (rst) begin
      m_s = 1; m_ps = 1; m_et = 0; m_cwp = 0; m_pil = 0; m_ef = 0; m_ec = 0; m_icc = 0;
      m_wim = 0; m_tbr = 0; m_rv = 0; m_lw = 0;
    end else begin
      cand.delete();
      m_rv = 0; m_lw = 0;
      x  = opnd_a ^ opnd_b;
      sm = opnd_a + opnd_b;
      if (op_bad || (op_wr_psr && m_s == 1 && int'(x[4:0]) >= 7)) cand.push_back(2);
      if (m_s == 0 && (op_rd_psr || op_rd_wim || op_rd_tbr || op_wr_psr || op_wr_wim || op_wr_tbr))
        cand.push_back(3);
      if (op_fp && m_ef == 0) cand.push_back(4);
      if (op_swtrap) cand.push_back(128 + int'(sm & 32'h7F));
      if (ext_trap_req) cand.push_back(int'(ext_trap_type));
      if (cand.size() > 0) begin
        if (m_et == 1) begin
          best = 1000;
          foreach (cand[i]) if (cand[i] < best) best = cand[i];
          m_ps = m_s; m_s = 1; m_et = 0; m_cwp = (m_cwp + 6) % 7;
          m_tbr = (m_tbr & 32'hFFFFF000) | (32'(best) << 4);
          m_rv = 1; m_rpc = m_tbr; m_rnpc = m_tbr + 4;
          m_lw = 1; m_lcwp = m_cwp; m_lpc = pc_in; m_lnpc = npc_in;
        end
      end else begin
        if (op_wr_psr) begin
          m_icc = int'(x[23:20]); m_ec = int'(x[13]); m_ef = int'(x[12]); m_pil = int'(x[11:8]);
          m_s = int'(x[7]); m_ps = int'(x[6]); m_et = int'(x[5]); m_cwp = int'(x[4:0]);
        end
        if (op_wr_wim) m_wim = x & 32'h7F;
        if (op_wr_tbr) m_tbr = x & 32'hFFFFF000;
        if (op_save) m_cwp = (m_cwp + 6) % 7;
        if (op_restore) m_cwp = (m_cwp + 1) % 7;
        if (op_rett) begin
          m_s = m_ps; m_et = 1; m_cwp = (m_cwp + 1) % 7;
          m_rv = 1; m_rpc = npc_in; m_rnpc = sm;
        end
      end
    end
    #1;
    if (!done) begin
      chk("model psr", psr_out, m_psr());
      chk("model wim", wim_out, m_wim);
      chk("model tbr", tbr_out, m_tbr);
      chk("model asi", {insn_asi, data_asi}, (m_s == 1) ? 16'h090B : 16'h080A);
      chk("model redirect", 32'(redir_valid), 32'(m_rv));
      chk("model link", 32'(link_we), 32'(m_lw));
      if (m_rv == 1) begin
        chk("model redir_pc", redir_pc, m_rpc);
        chk("model redir_npc", redir_npc, m_rnpc);
      end
      if (m_lw == 1) begin
        chk("model link_cwp", 32'(link_cwp), 32'(m_lcwp));
        chk("model link_pc", link_pc, m_lpc);
        chk("model link_npc", link_npc, m_lnpc);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic clr();
    op_rd_psr = 0; op_rd_wim = 0; op_rd_tbr = 0; op_wr_psr = 0; op_wr_wim = 0; op_wr_tbr = 0;
    op_save = 0; op_restore = 0; op_rett = 0; op_swtrap = 0; op_fp = 0; op_bad = 0;
    ext_trap_req = 0; ext_trap_type = 0; opnd_a = 0; opnd_b = 0;
  endtask

  task automatic fin();
    @(negedge clk);
    clr();
  endtask

  task automatic set_psr(input logic [31:0] v);
    @(negedge clk); clr();
    op_wr_psr = 1; opnd_a = v ^ 32'h0F0F0F0F; opnd_b = 32'h0F0F0F0F;
    fin();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clr();
    pc_in = 32'h0000_4000; npc_in = 32'h0000_4004;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 psr", psr_out, {IV, 24'h0000C0});
    chk("R1 wim/tbr", wim_out | tbr_out, 32'h0);
    chk("R1 asi", {insn_asi, data_asi}, 16'h090B);

    // R4 write with junk in reserved and fixed fields
    set_psr(32'hAB3FF0A3);
    chk("R4 psr write", psr_out, {IV, 24'h3030A3});

    // R4 window field 7 is rejected with illegal trap; R7, R8 trap entry
    pc_in = 32'h0000_1110; npc_in = 32'h0000_1114;
    set_psr(32'h000010A7);
    chk("R4 illegal redirect", {31'b0, redir_valid}, 32'h1);
    chk("R7 vector", redir_pc, 32'h0000_0020);
    chk("R7 vector npc", redir_npc, 32'h0000_0024);
    chk("R7 psr", psr_out, {IV, 24'h3030C2});
    chk("R8 link", {link_pc[15:0], link_npc[15:0]}, 32'h1110_1114);
    chk("R8 link window", 32'(link_cwp), 32'd2);

    // R5 masks
    set_psr(32'h000010A0);
    @(negedge clk); clr(); op_wr_wim = 1; opnd_a = 32'hFFFF0000; opnd_b = 32'h0000FFFF; fin();
    chk("R5 wim mask", wim_out, 32'h7F);
    @(negedge clk); clr(); op_wr_tbr = 1; opnd_a = 32'h12345FFF; fin();
    chk("R5 tbr mask", tbr_out, 32'h12345000);

    // R6 wrap both ways
    @(negedge clk); clr(); op_save = 1; fin();
    chk("R6 save wrap", 32'(psr_out[4:0]), 32'd6);
    @(negedge clk); clr(); op_restore = 1; fin();
    chk("R6 restore wrap", 32'(psr_out[4:0]), 32'd0);

    // R9 software trap vector
    @(negedge clk); clr(); op_swtrap = 1; opnd_a = 32'h10; opnd_b = 32'h75; fin();
    chk("R9 sw vector", redir_pc, 32'h12345850);

    // R13 return to user mode: S=1 PS=0 ET=0 window 5
    set_psr(32'h00001085);
    npc_in = 32'h0000_2000;
    @(negedge clk); clr(); op_rett = 1; opnd_a = 32'h100; opnd_b = 32'h4; fin();
    chk("R13 redirect", {redir_pc[15:0], redir_npc[15:0]}, 32'h2000_0104);
    chk("R13 psr", 32'(psr_out[7:0]), 32'h26);
    chk("R2 user asi", {insn_asi, data_asi}, 16'h080A);

    // R3 user write to mask refused
    @(negedge clk); clr(); op_wr_wim = 1; opnd_a = 32'h1; fin();
    chk("R3 priv vector", redir_pc, 32'h12345030);
    chk("R3 wim kept", wim_out, 32'h7F);
    chk("R2 super asi", {insn_asi, data_asi}, 16'h090B);

    // R10 FP disabled, then unrecognised op
    set_psr(32'h000000A3);
    @(negedge clk); clr(); op_fp = 1; fin();
    chk("R10 fp vector", redir_pc, 32'h12345040);
    set_psr(32'h000000A3);
    @(negedge clk); clr(); op_bad = 1; fin();
    chk("R10 illegal vector", redir_pc, 32'h12345020);

    // R11 arbitration
    set_psr(32'h000000A3);
    @(negedge clk); clr(); op_fp = 1; op_swtrap = 1; ext_trap_req = 1; ext_trap_type = 8'd9; fin();
    chk("R11 lowest fp", redir_pc, 32'h12345040);
    set_psr(32'h000000A3);
    @(negedge clk); clr(); op_fp = 1; ext_trap_req = 1; ext_trap_type = 8'd1; fin();
    chk("R11 lowest ext", redir_pc, 32'h12345010);

    // R12 traps disabled now: request and companion op ignored
    @(negedge clk); clr(); ext_trap_req = 1; ext_trap_type = 8'd6; op_wr_wim = 1; opnd_a = 32'h5; fin();
    chk("R12 no redirect", {31'b0, redir_valid}, 32'h0);
    chk("R12 wim kept", wim_out, 32'h7F);
    chk("R12 tbr kept", tbr_out, 32'h12345010);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule